// File: doc/BRIEF.md
# Brightness Ramp and Dither Engine

This block turns a brightness request into the duty word that a downstream PWM comparator uses once per output period. The request comes either from a 13-bit measured input duty or from an 8-bit brightness register, selected by a 2-bit mode code. A fourth mode bypasses the whole path and passes the raw input PWM level straight to a dedicated output. Before any ramping, the selected level is lowered by a thermal derating term whenever the die temperature exceeds a programmable limit.

The derated target is approached by a 16-bit ramp that moves a fixed step on each slow tick. The step is sized so that a full-scale change takes the time selected by a 3-bit slope code. While the ramp has not yet reached its target, up to three fractional bits below the output resolution are spread over successive periods. Some pulses in each group of periods are one LSB longer, so the average brightness moves more finely than the output word allows. Once the ramp sits on its target, the fractional bits are dropped and every period carries the same word.

Top module: `brt_slope_dither`

## Requirements
- R1: Source selection: mode 2'b00 and 2'b01 take the measured duty left-aligned into 16 bits (value << 3); mode 2'b10 takes the register left-aligned (value << 8). The output word is the top OUT_W bits of the ramp level.
- R2: In mode 2'b11 `direct_o` equals `pwm_in_i` of the previous clock, `duty_o` is 0 and the ramp level and dither phase are frozen. In every other mode `direct_o` is 0.
- R3: Slope codes 1..7 give 50, 75, 100, 150, 200, 300 and 500 ms. The ramp moves by step = ceil(65536 / (ms * TICKS_PER_MS)) once per tick, and a tick occurs every TICK_DIV clocks. Code 0 copies the target into the level on every clock, with no ramp.
- R4: Rising and falling ramps use the same step. The level never passes the target; a final step shorter than the full step lands exactly on it.
- R5: A target change during a ramp continues from the present level toward the new target, with no jump.
- R6: The dither code N (0..3) selects N fractional bits. These are the N highest bits of the 3 bits just below the output word. While the level differs from the target, period k (a 3-bit period counter) is one LSB longer when (k mod 2^N) < fraction. The word never exceeds all-ones.
- R7: When the level equals the target, the period word is exactly the top OUT_W bits of the level, whatever the dither code.
- R8: Temperature limit codes: 0 = off, 1 = 110, 2 = 120, 3 = 130 degrees. For each degree above the limit, the target drops by 1311 (2 % of full scale), with a floor at 0.
- R9: After reset, `duty_o` and `direct_o` are 0 and the ramp level and target are 0.
- R10: Outside mode 2'b11, `duty_o` changes only on a clock where `period_i` is high. The period counter advances on each such strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Source / pass-through select |
| meas_i | input | 13 | Measured input duty |
| reg_i | input | 8 | Brightness register value |
| slope_i | input | 3 | Ramp time code |
| dither_i | input | 2 | Number of fractional dither bits |
| tlim_i | input | 2 | Temperature limit code |
| temp_i | input | 8 | Die temperature, whole degrees |
| period_i | input | 1 | One-clock strobe at each output PWM period start |
| pwm_in_i | input | 1 | Raw input PWM level for pass-through |
| duty_o | output | OUT_W | Duty word for the next PWM period |
| direct_o | output | 1 | Pass-through PWM output |

## Verification
The embedded assertions check on every clock several properties. The ramp never crosses its target and stays frozen in pass-through. The duty word moves only on a period strobe, and when it moves it is at most one LSB above the truncated level. A settled level gives an undithered word. With derating off, the register source lands unaltered in the target. Only the bench scenarios can show the rest: the exact ramp duration per slope code, the distribution of lengthened pulses for each dither depth, the derating amounts and floor, and a mid-ramp retarget. The behavioural reference model compared on each clock covers these.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int RAMP_W         = 16;
    localparam int FULL_SCALE     = 65536;
    localparam int DERATE_PER_DEG = 1311;
    localparam int FRAC_MAX       = 3;

    typedef enum logic [1:0] {
        SRC_MEAS_A = 2'b00,
        SRC_MEAS_B = 2'b01,
        SRC_REG    = 2'b10,
        SRC_DIRECT = 2'b11
    } src_mode_e;

    typedef struct packed {
        logic [RAMP_W-1:0] level;
        logic [RAMP_W-1:0] target;
        logic              hold;
    } ramp_view_t;

    function automatic int slope_ms(input logic [2:0] code);
        case (code)
            3'd1:    return 50;
            3'd2:    return 75;
            3'd3:    return 100;
            3'd4:    return 150;
            3'd5:    return 200;
            3'd6:    return 300;
            3'd7:    return 500;
            default: return 0;
        endcase
    endfunction

    function automatic logic [RAMP_W:0] step_size(input logic [2:0] code, input int tpm);
        int n;
        n = slope_ms(code) * tpm;
        if (n <= 0) return (RAMP_W+1)'(FULL_SCALE);
        return (RAMP_W+1)'((FULL_SCALE + n - 1) / n);
    endfunction

    function automatic int limit_deg(input logic [1:0] code);
        case (code)
            2'd1:    return 110;
            2'd2:    return 120;
            2'd3:    return 130;
            default: return 0;
        endcase
    endfunction

    function automatic logic [RAMP_W-1:0] derate(input logic [RAMP_W-1:0] lvl,
                                                 input logic [1:0]        lim_code,
                                                 input logic [7:0]        temp);
        int over;
        int cut;
        if (lim_code == 2'd0) return lvl;
        over = int'(temp) - limit_deg(lim_code);
        if (over <= 0) return lvl;
        cut = over * DERATE_PER_DEG;
        if (cut >= int'(lvl)) return '0;
        return RAMP_W'(int'(lvl) - cut);
    endfunction

endpackage

// File: rtl/brt_target.sv
module brt_target
    import brt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  src_mode_e         mode,
    input  logic [12:0]       meas,
    input  logic [7:0]        regv,
    input  logic [1:0]        tlim,
    input  logic [7:0]        temp,
    output logic [RAMP_W-1:0] target
);
    logic [RAMP_W-1:0] aligned;

    always_comb begin
        case (mode)
            SRC_REG: aligned = {regv, 8'h00};
            default: aligned = {meas, 3'b000};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) target <= '0;
        else     target <= derate(aligned, tlim, temp);
    end

    p_no_derate_r8: assert property (@(posedge clk) disable iff (rst)
        (tlim == 2'd0 && mode == SRC_REG) |=> target == {$past(regv), 8'h00});

endmodule

// File: rtl/brt_ramp.sv
module brt_ramp
    import brt_pkg::*;
#(
    parameter int TICK_DIV     = 100,
    parameter int TICKS_PER_MS = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [2:0]        slope,
    input  logic [RAMP_W-1:0] target,
    output logic [RAMP_W-1:0] level
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic [RAMP_W:0]   step;
    logic [RAMP_W:0]   gap_up;
    logic [RAMP_W:0]   gap_dn;
    logic [RAMP_W-1:0] level_d;

    assign tick   = (div_q == DIV_LAST);
    assign step   = step_size(slope, TICKS_PER_MS);
    assign gap_up = {1'b0, target} - {1'b0, level};
    assign gap_dn = {1'b0, level} - {1'b0, target};

    always_comb begin
        level_d = level;
        if (!hold) begin
            if (slope == 3'd0) begin
                level_d = target;
            end else if (tick) begin
                if (level < target)
                    level_d = (gap_up > step) ? level + step[RAMP_W-1:0] : target;
                else if (level > target)
                    level_d = (gap_dn > step) ? level - step[RAMP_W-1:0] : target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            level <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            level <= level_d;
        end
    end

    p_no_overshoot_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(level) <= $past(target)) |-> (level <= $past(target)));
    p_no_undershoot_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(level) >= $past(target)) |-> (level >= $past(target)));
    p_hold_level_r2: assert property (@(posedge clk) disable iff (rst)
        hold |=> level == $past(level));

endmodule

// File: rtl/brt_dither.sv
module brt_dither
    import brt_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  ramp_view_t       view,
    input  logic             period,
    input  logic [1:0]       nfrac,
    output logic [OUT_W-1:0] duty
);
    localparam int LOW_TOP = RAMP_W - OUT_W - 1;

    logic [OUT_W-1:0]    base;
    logic [FRAC_MAX-1:0] window;
    logic [FRAC_MAX-1:0] frac;
    logic [FRAC_MAX-1:0] mask;
    logic [FRAC_MAX-1:0] phase_q;
    logic                moving;
    logic                stretch;

    assign base    = view.level[RAMP_W-1 -: OUT_W];
    assign window  = view.level[LOW_TOP -: FRAC_MAX];
    assign frac    = window >> (FRAC_MAX - int'(nfrac));
    assign mask    = FRAC_MAX'((1 << nfrac) - 1);
    assign moving  = (view.level != view.target);
    assign stretch = moving && ((phase_q & mask) < frac) && (base != '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty    <= '0;
            phase_q <= '0;
        end else if (view.hold) begin
            duty    <= '0;
        end else if (period) begin
            duty    <= base + OUT_W'(stretch);
            phase_q <= phase_q + 1'b1;
        end
    end

    p_direct_zero_r2: assert property (@(posedge clk) disable iff (rst)
        view.hold |=> duty == '0);
    p_only_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (!view.hold && !period) |=> $stable(duty));
    p_one_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        (!view.hold && period) |=>
            (duty == $past(base) || duty == $past(base) + 1'b1));
    p_steady_plain_r7: assert property (@(posedge clk) disable iff (rst)
        (!view.hold && period && !moving) |=> duty == $past(base));

endmodule

// File: rtl/brt_slope_dither.sv
module brt_slope_dither
    import brt_pkg::*;
#(
    parameter int OUT_W    = 10,
    parameter int REF_KHZ  = 5000,
    parameter int TICK_DIV = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [12:0]      meas_i,
    input  logic [7:0]       reg_i,
    input  logic [2:0]       slope_i,
    input  logic [1:0]       dither_i,
    input  logic [1:0]       tlim_i,
    input  logic [7:0]       temp_i,
    input  logic             period_i,
    input  logic             pwm_in_i,
    output logic [OUT_W-1:0] duty_o,
    output logic             direct_o
);
    localparam int TICKS_PER_MS = REF_KHZ / TICK_DIV;

    initial begin
        if (OUT_W + FRAC_MAX > RAMP_W || OUT_W < 1)
            $error("OUT_W must leave room for the dither bits");
        if (TICKS_PER_MS < 1)
            $error("TICK_DIV too large for REF_KHZ");
    end

    src_mode_e         mode;
    logic [RAMP_W-1:0] target;
    logic [RAMP_W-1:0] level;
    ramp_view_t        view;

    assign mode = src_mode_e'(mode_i);

    brt_target u_target (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .meas   (meas_i),
        .regv   (reg_i),
        .tlim   (tlim_i),
        .temp   (temp_i),
        .target (target)
    );

    brt_ramp #(
        .TICK_DIV     (TICK_DIV),
        .TICKS_PER_MS (TICKS_PER_MS)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .hold   (mode == SRC_DIRECT),
        .slope  (slope_i),
        .target (target),
        .level  (level)
    );

    assign view.level  = level;
    assign view.target = target;
    assign view.hold   = (mode == SRC_DIRECT);

    brt_dither #(
        .OUT_W (OUT_W)
    ) u_dither (
        .clk    (clk),
        .rst    (rst),
        .view   (view),
        .period (period_i),
        .nfrac  (dither_i),
        .duty   (duty_o)
    );

    always_ff @(posedge clk) begin
        if (rst) direct_o <= 1'b0;
        else     direct_o <= (mode == SRC_DIRECT) ? pwm_in_i : 1'b0;
    end

    p_direct_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> direct_o == $past(pwm_in_i));
    p_direct_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'b11) |=> !direct_o);

endmodule

// File: tb/brt_slope_dither_bench.sv
`timescale 1ns/1ps
module brt_slope_dither_bench;
    localparam int OUT_W    = 10;
    localparam int REF_KHZ  = 4;
    localparam int TICK_DIV = 2;
    localparam int TPM      = REF_KHZ / TICK_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]  mode_i   = 2'b10;
    logic [12:0] meas_i   = '0;
    logic [7:0]  reg_i    = '0;
    logic [2:0]  slope_i  = '0;
    logic [1:0]  dither_i = '0;
    logic [1:0]  tlim_i   = '0;
    logic [7:0]  temp_i   = 8'd25;
    logic        period_i = 1'b0;
    logic        pwm_in_i = 1'b0;
    logic [OUT_W-1:0] duty_o;
    logic        direct_o;

    always #2.5 clk = ~clk;

    brt_slope_dither #(.OUT_W(OUT_W), .REF_KHZ(REF_KHZ), .TICK_DIV(TICK_DIV))
    u_brt_slope_dither (
        .clk(clk), .rst(rst), .mode_i(mode_i), .meas_i(meas_i), .reg_i(reg_i),
        .slope_i(slope_i), .dither_i(dither_i), .tlim_i(tlim_i), .temp_i(temp_i),
        .period_i(period_i), .pwm_in_i(pwm_in_i), .duty_o(duty_o), .direct_o(direct_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R9";

    // behavioural reference
    int m_tgt, m_cur, m_duty, m_cnt, m_div, m_dir;

    function automatic int ms_of(int c);
        int t[8] = '{0, 50, 75, 100, 150, 200, 300, 500};
        return t[c];
    endfunction

    always @(posedge clk) begin
        int nt, nc, nd, ndu, ncn, st, base, w, fr, k;
        bit tick;
        if (rst) begin
            m_tgt = 0; m_cur = 0; m_duty = 0; m_cnt = 0; m_div = 0; m_dir = 0;
        end else begin
            nt = (mode_i == 2'b10) ? reg_i * 256 : meas_i * 8;
            if (tlim_i != 0 && temp_i > 100 + 10 * tlim_i) begin
                nt = nt - (temp_i - (100 + 10 * tlim_i)) * 1311;
                if (nt < 0) nt = 0;
            end
            tick = (m_div == TICK_DIV - 1);
            nd = tick ? 0 : m_div + 1;
            nc = m_cur;
            ndu = m_duty;
            ncn = m_cnt;
            if (mode_i == 2'b11) begin
                ndu = 0;
            end else begin
                if (slope_i == 0) nc = m_tgt;
                else if (tick) begin
                    st = (65536 + ms_of(slope_i) * TPM - 1) / (ms_of(slope_i) * TPM);
                    if (m_cur < m_tgt) nc = (m_cur + st > m_tgt) ? m_tgt : m_cur + st;
                    else if (m_cur > m_tgt) nc = (m_cur - st < m_tgt) ? m_tgt : m_cur - st;
                end
                if (period_i) begin
                    base = m_cur / 64;
                    w = (m_cur / 8) % 8;
                    fr = w / (8 >> dither_i);
                    k = m_cnt % (1 << dither_i);
                    ndu = base + ((m_cur != m_tgt && k < fr && base < 1023) ? 1 : 0);
                    ncn = (m_cnt + 1) % 8;
                end
            end
            m_dir = (mode_i == 2'b11) ? int'(pwm_in_i) : 0;
            m_tgt = nt; m_cur = nc; m_div = nd; m_duty = ndu; m_cnt = ncn;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (int'(duty_o) != m_duty || int'(direct_o) != m_dir) begin
                n_bad++;
                $display("FAIL %s: duty=%0d direct=%0d expected duty=%0d direct=%0d",
                         phase, duty_o, direct_o, m_duty, m_dir);
            end
        end
    end

    // period strobe generator
    int strobe_gap = 0;
    int sg_cnt = 0;
    always @(negedge clk) begin
        if (strobe_gap == 0) period_i <= 1'b0;
        else begin
            sg_cnt = (sg_cnt + 1) % strobe_gap;
            period_i <= (sg_cnt == 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        phase = "R9";
        check(duty_o == 0, "R9 duty after reset", duty_o, 0);
        check(direct_o == 0, "R9 direct after reset", direct_o, 0);

        // R1 register source, immediate slope (R3 code 0)
        phase = "R1";
        strobe_gap = 4;
        reg_i = 8'hA5;
        cyc(12);
        check(duty_o == 660, "R1 register aligned", duty_o, 660);
        mode_i = 2'b00; meas_i = 13'h1555;
        cyc(12);
        check(duty_o == 682, "R1 measured aligned", duty_o, 682);
        mode_i = 2'b01; meas_i = 13'h0040;
        cyc(12);
        check(duty_o == 8, "R1 measured mode 01", duty_o, 8);

        // R10 duty only on strobe
        phase = "R10";
        strobe_gap = 0;
        cyc(2);
        mode_i = 2'b10; reg_i = 8'h20;
        cyc(20);
        check(duty_o == 8, "R10 no strobe no change", duty_o, 8);
        strobe_gap = 4;
        cyc(12);
        check(duty_o == 128, "R10 strobe applies", duty_o, 128);

        // R3/R4 slow full ramp up, 500 ms
        phase = "R3";
        reg_i = 8'h00;
        cyc(12);
        slope_i = 3'd7; reg_i = 8'hFF;
        cyc(1000);
        check(duty_o > 0 && duty_o < 1020, "R3 mid ramp", duty_o, 510);
        cyc(1100);
        check(duty_o == 1020, "R3 ramp done", duty_o, 1020);
        // R4 falling with same slope
        phase = "R4";
        reg_i = 8'h00;
        cyc(1000);
        check(duty_o > 0 && duty_o < 1020, "R4 mid fall", duty_o, 510);
        cyc(1100);
        check(duty_o == 0, "R4 fall done", duty_o, 0);
        // short slope codes
        for (int c = 1; c < 7; c++) begin
            slope_i = 3'(c);
            reg_i = (c % 2) ? 8'hC3 : 8'h11;
            cyc(ms_of(c) * TPM * TICK_DIV + 40);
        end

        // R5 retarget mid ramp
        phase = "R5";
        slope_i = 3'd5;
        reg_i = 8'hF0;
        cyc(300);
        reg_i = 8'h40;
        cyc(900);
        check(duty_o == 256, "R5 retarget settled", duty_o, 256);

        // R6 dither depths during ramps, R7 steady state
        for (int d = 0; d < 4; d++) begin
            phase = "R6";
            dither_i = 2'(d);
            strobe_gap = 1 + d;
            slope_i = 3'd7;
            reg_i = (d % 2) ? 8'h10 : 8'hE7;
            cyc(2100);
            phase = "R7";
            cyc(40);
            check(duty_o == (((d % 2) ? 16 : 231) * 4), "R7 steady undithered",
                  duty_o, ((d % 2) ? 16 : 231) * 4);
        end

        // R8 thermal derating
        phase = "R8";
        slope_i = 3'd0; dither_i = 2'd0; strobe_gap = 3;
        reg_i = 8'hFF; tlim_i = 2'd1; temp_i = 8'd115;
        cyc(12);
        check(duty_o == 917, "R8 derate 5 deg", duty_o, 917);
        temp_i = 8'd200;
        cyc(12);
        check(duty_o == 0, "R8 derate floor", duty_o, 0);
        tlim_i = 2'd3; temp_i = 8'd131;
        cyc(12);
        check(duty_o == 999, "R8 limit 130", duty_o, 999);
        tlim_i = 2'd0;
        cyc(12);
        check(duty_o == 1020, "R8 derate off", duty_o, 1020);

        // R2 pass-through
        phase = "R2";
        slope_i = 3'd6; reg_i = 8'h80;
        cyc(200);
        mode_i = 2'b11;
        reg_i = 8'h05;
        for (int i = 0; i < 40; i++) begin
            pwm_in_i = (i % 3 == 0);
            cyc(1);
            check(direct_o == ((i % 3) == 0), "R2 direct follows", direct_o, (i % 3) == 0);
            check(duty_o == 0, "R2 duty zero", duty_o, 0);
        end
        mode_i = 2'b10;
        cyc(1400);

        summary();
        $finish;
    end
endmodule